// File: doc/BRIEF.md
# RV32 SHA-512 Half-Word Helper Unit

This execute-stage unit serves a 32-bit RISC-V core that computes SHA-512 with 32-bit registers. Each 64-bit SHA-512 value is held as a high word and a low word. The unit computes one 32-bit half of a SHA-512 sigma or sum function from two such words. The 64-bit rotates become pairs of logical shifts, one on each source word. The high and low forms of a sigma differ only in the extra terms from the second operand. Those terms carry in the bits that cross the 32-bit boundary.

Each cycle the unit takes an instruction word, two source operands and a valid strobe. It reports at once whether it claims the instruction. It returns the result with a result-valid bit, either in the same cycle or one cycle later, as the `OUT_REG` parameter selects. The unit claims nothing while the core runs in 64-bit mode.

Top module: `sha512h_unit`

## Requirements
- R1: `claim` is high, in the same cycle and whatever `in_valid` is, exactly when all of the following hold: `instr[6:0]` is 7'b0110011, `instr[31:30]` is 2'b01, `instr[14:12]` is 3'b000, `instr[29:25]` is one of 0x08, 0x09, 0x0a, 0x0b, 0x0e or 0x0f, and `mode_rv64` is low. Bits 24:15 and 11:7 are ignored.
- R2: While `mode_rv64` is high, `claim` is low for every instruction and no result is marked valid.
- R3: Code 0x0e (sigma0, high half) gives a>>1 ^ a>>7 ^ a>>8 ^ b<<31 ^ b<<24, where a is `src_a`, b is `src_b` and all shifts are 32-bit logical. This equals the upper word of SHA-512 sigma0 of {a,b}.
- R4: Code 0x0a (sigma0, low half) gives a>>1 ^ a>>7 ^ a>>8 ^ b<<31 ^ b<<25 ^ b<<24. This equals the lower word of sigma0 of {b,a}.
- R5: Code 0x0f (sigma1, high half) gives a<<3 ^ a>>6 ^ a>>19 ^ b>>29 ^ b<<13. This equals the upper word of sigma1 of {a,b}.
- R6: Code 0x0b (sigma1, low half) gives the R5 expression ^ b<<26. This equals the lower word of sigma1 of {b,a}.
- R7: Code 0x08 (sum0) gives a>>28 ^ a<<30 ^ a<<25 ^ b<<4 ^ b>>2 ^ b>>7. This equals the lower word of Sigma0 of {b,a}.
- R8: Code 0x09 (sum1) gives a>>14 ^ a>>18 ^ a<<23 ^ b<<18 ^ b<<14 ^ b>>9. This equals the lower word of Sigma1 of {b,a}.
- R9: `out_valid` reports `in_valid & claim` for the stimulus it belongs to. `result` is zero whenever `out_valid` is low.
- R10: With `OUT_REG`=1, `result` and `out_valid` appear one clock after their inputs. With `OUT_REG`=0, they appear in the same cycle as their inputs.
- R11: With `OUT_REG`=1, a synchronous `rst` clears `out_valid` and `result` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| mode_rv64 | input | 1 | High while the core runs in 64-bit mode |
| in_valid | input | 1 | Instruction and operands are valid |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| claim | output | 1 | Instruction is one of the six helper operations (combinational) |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Computed half-word |

## Verification
`claim` depends only on the inputs of the current cycle. The bench checks it one time unit after each new stimulus is driven.

The bench builds two copies of the unit. The combinational copy (`OUT_REG`=0) is compared with the model for the stimulus it is holding at that moment. The registered copy (`dut`, `OUT_REG`=1) is compared on the following falling edge with the prediction saved from the previous stimulus. That prediction is forced to zero when reset was high at the edge that captured it.

The model builds the 64-bit word and applies true 64-bit rotates, so the expected values do not copy the shift pairs used in the design.

// File: rtl/sha512h_pkg.sv
package sha512h_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam logic [6:0]  OPC_REG = 7'b0110011;
    localparam logic [1:0]  BSEL_OK = 2'b01;
    localparam logic [2:0]  F3_OK   = 3'b000;

    localparam logic [4:0] CODE_SUM0  = 5'h08;
    localparam logic [4:0] CODE_SUM1  = 5'h09;
    localparam logic [4:0] CODE_SIG0L = 5'h0a;
    localparam logic [4:0] CODE_SIG1L = 5'h0b;
    localparam logic [4:0] CODE_SIG0H = 5'h0e;
    localparam logic [4:0] CODE_SIG1H = 5'h0f;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SIG0H,
        OP_SIG0L,
        OP_SIG1H,
        OP_SIG1L,
        OP_SUM0,
        OP_SUM1
    } sha_op_e;
endpackage

// File: rtl/sha512h_decode.sv
module sha512h_decode
    import sha512h_pkg::*;
(
    input  logic [31:0] instr,
    input  logic        mode_rv64,
    output sha_op_e     op,
    output logic        hit
);
    logic [4:0] code;
    logic       frame_ok;
    sha_op_e    sel;

    assign code     = instr[29:25];
    assign frame_ok = (instr[6:0] == OPC_REG) && (instr[31:30] == BSEL_OK)
                   && (instr[14:12] == F3_OK) && !mode_rv64;

    always_comb begin
        unique case (code)
            CODE_SIG0H: sel = OP_SIG0H;
            CODE_SIG0L: sel = OP_SIG0L;
            CODE_SIG1H: sel = OP_SIG1H;
            CODE_SIG1L: sel = OP_SIG1L;
            CODE_SUM0:  sel = OP_SUM0;
            CODE_SUM1:  sel = OP_SUM1;
            default:    sel = OP_NONE;
        endcase
    end

    assign op  = frame_ok ? sel : OP_NONE;
    assign hit = (op != OP_NONE);
endmodule

// File: rtl/sha512h_datapath.sv
module sha512h_datapath
    import sha512h_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  sha_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    logic [W-1:0] sig0_base, sig1_base;

    assign sig0_base = (a >> 1) ^ (a >> 7) ^ (a >> 8) ^ (b << 31) ^ (b << 24);
    assign sig1_base = (a << 3) ^ (a >> 6) ^ (a >> 19) ^ (b >> 29) ^ (b << 13);

    always_comb begin
        unique case (op)
            OP_SIG0H: y = sig0_base;
            OP_SIG0L: y = sig0_base ^ (b << 25);
            OP_SIG1H: y = sig1_base;
            OP_SIG1L: y = sig1_base ^ (b << 26);
            OP_SUM0:  y = (a >> 28) ^ (a << 30) ^ (a << 25)
                        ^ (b << 4) ^ (b >> 2) ^ (b >> 7);
            OP_SUM1:  y = (a >> 14) ^ (a >> 18) ^ (a << 23)
                        ^ (b << 18) ^ (b << 14) ^ (b >> 9);
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/sha512h_outstage.sv
module sha512h_outstage #(
    parameter int unsigned W       = 32,
    parameter bit          OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         v_in,
    input  logic [W-1:0] d_in,
    output logic         v_out,
    output logic [W-1:0] d_out
);
    logic [W-1:0] gated;
    assign gated = v_in ? d_in : '0;

    generate
        if (OUT_REG) begin : g_reg
            logic         v_q;
            logic [W-1:0] d_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    v_q <= 1'b0;
                    d_q <= '0;
                end else begin
                    v_q <= v_in;
                    d_q <= gated;
                end
            end
            assign v_out = v_q;
            assign d_out = d_q;
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk ^ rst;
            assign v_out = v_in;
            assign d_out = gated;
        end
    endgenerate
endmodule

// File: rtl/sha512h_unit.sv
module sha512h_unit
    import sha512h_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mode_rv64,
    input  logic        in_valid,
    input  logic [31:0] instr,
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    output logic        claim,
    output logic        out_valid,
    output logic [31:0] result
);
    sha_op_e     op;
    logic [31:0] raw;

    sha512h_decode u_dec (
        .instr     (instr),
        .mode_rv64 (mode_rv64),
        .op        (op),
        .hit       (claim)
    );

    sha512h_datapath #(.W(WORD_W)) u_dp (
        .op (op),
        .a  (src_a),
        .b  (src_b),
        .y  (raw)
    );

    sha512h_outstage #(.W(WORD_W), .OUT_REG(OUT_REG)) u_out (
        .clk   (clk),
        .rst   (rst),
        .v_in  (in_valid & claim),
        .d_in  (raw),
        .v_out (out_valid),
        .d_out (result)
    );
endmodule

// File: rtl/sha512h_chk.sv
module sha512h_chk #(
    parameter bit OUT_REG = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        mode_rv64,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic        claim,
    input logic        out_valid,
    input logic [31:0] result
);
    // R2
    no_claim_rv64_chk: assert property (@(posedge clk) disable iff (rst)
        mode_rv64 |-> !claim);

    // R1
    claim_frame_chk: assert property (@(posedge clk) disable iff (rst)
        claim |-> (instr[6:0] == 7'b0110011 && instr[14:12] == 3'b000 && instr[31:30] == 2'b01));

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (result == 32'd0));

    generate
        if (OUT_REG) begin : g_reg
            // R10
            valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> $past(in_valid && claim));
            // R11
            rst_clear_chk: assert property (@(posedge clk)
                rst |=> (!out_valid && result == 32'd0));
        end else begin : g_comb
            // R10
            valid_now_chk: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> (in_valid && claim));
        end
    endgenerate
endmodule

bind sha512h_unit sha512h_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_rv64 (mode_rv64),
    .in_valid  (in_valid),
    .instr     (instr),
    .claim     (claim),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/tb_sha512h_unit.sv
`timescale 1ns/1ps
module tb_sha512h_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_rv64 = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        claim_r, claim_c, ov_r, ov_c;
    logic [31:0] res_r, res_c;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic        pend_v = 1'b0;
    logic [31:0] pend_d = '0;
    string       pend_tag = "R11";

    always #10 clk = ~clk;

    sha512h_unit #(.OUT_REG(1'b1)) dut (
        .clk(clk), .rst(rst), .mode_rv64(mode_rv64), .in_valid(in_valid),
        .instr(instr), .src_a(src_a), .src_b(src_b),
        .claim(claim_r), .out_valid(ov_r), .result(res_r));

    sha512h_unit #(.OUT_REG(1'b0)) dut_c (
        .clk(clk), .rst(rst), .mode_rv64(mode_rv64), .in_valid(in_valid),
        .instr(instr), .src_a(src_a), .src_b(src_b),
        .claim(claim_c), .out_valid(ov_c), .result(res_c));

    function automatic logic [63:0] ror(input logic [63:0] x, input int n);
        return (x >> n) | (x << (64 - n));
    endfunction

    function automatic logic [63:0] s0(input logic [63:0] x);
        return ror(x, 1) ^ ror(x, 8) ^ (x >> 7);
    endfunction
    function automatic logic [63:0] s1(input logic [63:0] x);
        return ror(x, 19) ^ ror(x, 61) ^ (x >> 6);
    endfunction
    function automatic logic [63:0] b0(input logic [63:0] x);
        return ror(x, 28) ^ ror(x, 34) ^ ror(x, 39);
    endfunction
    function automatic logic [63:0] b1(input logic [63:0] x);
        return ror(x, 14) ^ ror(x, 18) ^ ror(x, 41);
    endfunction

    function automatic logic [31:0] mk(input logic [4:0] code, input logic [1:0] bs,
                                       input logic [2:0] f3, input logic [6:0] opc);
        logic [9:0] mid = 10'($urandom);
        logic [4:0] rd = 5'($urandom);
        return {bs, code, mid, f3, rd, opc};
    endfunction

    // Model: decode from the encoding rules and evaluate with 64-bit rotates.
    task automatic model(output logic cl, output logic [31:0] y, output string tag);
        logic [4:0] code = instr[29:25];
        bit frame = instr[6:0] == 7'b0110011 && instr[31:30] == 2'b01
                    && instr[14:12] == 3'b000;
        cl = 1'b1;
        tag = "R1";
        y = '0;
        case (code)
            5'h0e: begin y = s0({src_a, src_b})[63:32]; tag = "R3"; end
            5'h0a: begin y = s0({src_b, src_a})[31:0];  tag = "R4"; end
            5'h0f: begin y = s1({src_a, src_b})[63:32]; tag = "R5"; end
            5'h0b: begin y = s1({src_b, src_a})[31:0];  tag = "R6"; end
            5'h08: begin y = b0({src_b, src_a})[31:0];  tag = "R7"; end
            5'h09: begin y = b1({src_b, src_a})[31:0];  tag = "R8"; end
            default: cl = 1'b0;
        endcase
        if (!frame) cl = 1'b0;
        if (mode_rv64) begin cl = 1'b0; tag = "R2"; end
        if (!(cl && in_valid)) begin
            y = '0;
            if (tag != "R2") tag = "R9";
        end
    endtask

    task automatic chk1(input string tag, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Called at a falling edge: check the registered copy, drive, check the comb copy.
    task automatic step(input logic r, input logic m, input logic v, input logic [31:0] ins,
                        input logic [31:0] a, input logic [31:0] b);
        logic cl;
        logic [31:0] y;
        string tag;
        chk1(pend_tag, "R10 reg valid", {31'd0, ov_r}, {31'd0, pend_v});
        chk1(pend_tag, "R10 reg result", res_r, pend_d);
        rst = r; mode_rv64 = m; in_valid = v; instr = ins; src_a = a; src_b = b;
        #1;
        model(cl, y, tag);
        chk1(m ? "R2" : "R1", "claim", {31'd0, claim_c}, {31'd0, cl});
        chk1(m ? "R2" : "R1", "claim reg copy", {31'd0, claim_r}, {31'd0, cl});
        chk1(tag, "comb valid", {31'd0, ov_c}, {31'd0, cl & v});
        chk1(tag, "comb result", res_c, y);
        pend_v = r ? 1'b0 : (cl & v);
        pend_d = r ? '0 : y;
        pend_tag = r ? "R11" : tag;
        @(negedge clk);
    endtask

    localparam logic [4:0] CODES [6] = '{5'h08, 5'h09, 5'h0a, 5'h0b, 5'h0e, 5'h0f};
    localparam logic [6:0] OPC = 7'b0110011;

    initial begin
        @(negedge clk);
        // R11: reset with live legal stimulus
        for (int i = 0; i < 3; i++)
            step(1'b1, 1'b0, 1'b1, mk(5'h08, 2'b01, 3'b000, OPC), 32'hffffffff, 32'h12345678);
        // directed: each op, corner operands
        for (int k = 0; k < 6; k++) begin
            step(1'b0, 1'b0, 1'b1, mk(CODES[k], 2'b01, 3'b000, OPC), 32'h00000001, 32'h00000000);
            step(1'b0, 1'b0, 1'b1, mk(CODES[k], 2'b01, 3'b000, OPC), 32'h00000000, 32'h80000001);
            step(1'b0, 1'b0, 1'b1, mk(CODES[k], 2'b01, 3'b000, OPC), 32'hffffffff, 32'hffffffff);
            step(1'b0, 1'b0, 1'b1, mk(CODES[k], 2'b01, 3'b000, OPC), 32'h6a09e667, 32'hf3bcc908);
            // R9: claimed but not valid
            step(1'b0, 1'b0, 1'b0, mk(CODES[k], 2'b01, 3'b000, OPC), 32'hdeadbeef, 32'hcafef00d);
            // R2: 64-bit mode
            step(1'b0, 1'b1, 1'b1, mk(CODES[k], 2'b01, 3'b000, OPC), 32'hdeadbeef, 32'hcafef00d);
            // R1: wrong byte-select, funct3, opcode
            step(1'b0, 1'b0, 1'b1, mk(CODES[k], 2'b00, 3'b000, OPC), 32'h1, 32'h2);
            step(1'b0, 1'b0, 1'b1, mk(CODES[k], 2'b11, 3'b000, OPC), 32'h1, 32'h2);
            step(1'b0, 1'b0, 1'b1, mk(CODES[k], 2'b01, 3'b001, OPC), 32'h1, 32'h2);
            step(1'b0, 1'b0, 1'b1, mk(CODES[k], 2'b01, 3'b000, 7'b0010011), 32'h1, 32'h2);
        end
        // R1: neighbouring codes not claimed
        step(1'b0, 1'b0, 1'b1, mk(5'h0c, 2'b01, 3'b000, OPC), 32'h5, 32'h6);
        step(1'b0, 1'b0, 1'b1, mk(5'h11, 2'b01, 3'b000, OPC), 32'h5, 32'h6);
        // R11: reset in mid-stream
        step(1'b1, 1'b0, 1'b1, mk(5'h09, 2'b01, 3'b000, OPC), 32'h5, 32'h6);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] ins;
            int sel = $urandom_range(0, 9);
            if (sel < 7) ins = mk(CODES[$urandom_range(0, 5)], 2'b01, 3'b000, OPC);
            else if (sel == 7) ins = mk(5'($urandom), 2'($urandom), 3'($urandom), OPC);
            else ins = $urandom;
            step($urandom_range(0, 99) == 0, $urandom_range(0, 9) == 0,
                 $urandom_range(0, 3) != 0, ins, $urandom, $urandom);
        end
        step(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule